// File: doc/BRIEF.md
# Threshold-Driven Counter Flush Scheduler

This block keeps a bank of narrow on-chip event counters that stand in front of full-width counters held in a slower backing store. Each accepted update request names one counter, and that on-chip counter goes up by one. The backing store is never written directly by an update. After every fixed number of accepted updates, the block spends one cycle choosing a single counter, reports its index and value on a flush port so that the backing store can add the value, and clears that counter on chip.

The choice avoids a full sort. A single register follows the largest recently updated counter. A one-bit-per-counter map marks every counter whose value has reached the threshold. If the tracked counter has reached the threshold, it is chosen. If it has not, the lowest-indexed counter marked in the map is chosen. If no counter is marked, the tracked counter is chosen anyway. A counter that would wrap saturates instead and raises a sticky overflow flag.

Top module: `fs_flush_sched`

## Requirements
- R1: After reset, `upd_ready` is 1, `flush_valid` is 0, `overflow` is 0 and every counter holds zero.
- R2: An update is accepted on a rising edge where `upd_valid` and `upd_ready` are both 1; it raises counter `upd_idx` by exactly one and touches no other counter.
- R3: Once every UPD_PER_FLUSH accepted updates, `upd_ready` is 0 for the single cycle that follows the edge accepting the last of them, and `flush_valid` is 1 for exactly the one cycle after that, with `upd_ready` back at 1.
- R4: `flush_value` is the chosen counter's value just before the flush, and that counter reads as zero afterwards (its later flushes count from zero).
- R5: If the tracked largest counter holds a value of at least THRESH, it is the one flushed.
- R6: If the tracked counter is below THRESH and at least one counter is at or above THRESH, the lowest-indexed such counter is flushed.
- R7: If no counter is at or above THRESH, the tracked largest counter is flushed.
- R8: A counter's threshold mark is set by the increment that makes it reach THRESH and is cleared when it is flushed, so the mark always equals (value >= THRESH).
- R9: The tracker takes the updated counter when the tracker is empty, when the new value is strictly greater than the held value, or when the index matches; on a tie the earlier counter stays. Flushing the tracked counter empties the tracker, and only later updates refill it.
- R10: An increment of a counter already at 2^CTR_W-1 leaves it there and sets `overflow`, which stays 1 until reset.
- R11: A request presented while `upd_ready` is 0 is not accepted and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_valid | input | 1 | Update request present |
| upd_ready | output | 1 | Block can take an update this cycle |
| upd_idx | input | $clog2(N_CTRS) | Counter to increment |
| flush_valid | output | 1 | One-cycle pulse: flush port carries a counter |
| flush_idx | output | $clog2(N_CTRS) | Index of the flushed counter |
| flush_value | output | CTR_W | Value of the flushed counter before clearing |
| overflow | output | 1 | Sticky flag: a saturating increment occurred |

## Verification
The two functions that could meet in one cycle are an increment and a flush reset, and since the flush target is often the counter just updated they could land on the same index. The bench holds `upd_valid` high through every flush slot with back-to-back updates to the counters most likely to be chosen, and judges that `upd_ready` drops for exactly that slot, that the held request is taken only afterwards, and that every later flushed value matches a model in which no increment was lost to or merged with a reset. Directed groups select each of the three selection rules and saturation; a long pseudo-random stream with idle gaps then sweeps the interplay.

// File: rtl/fs_pkg.sv
package fs_pkg;

    // Which selection rule produced the flush target
    typedef enum logic [1:0] {
        PICK_TRACKED  = 2'd0,
        PICK_MARKED   = 2'd1,
        PICK_FALLBACK = 2'd2
    } pick_e;

endpackage

// File: rtl/fs_ctr_bank.sv
module fs_ctr_bank #(
    parameter int N_CTRS = 8,
    parameter int CTR_W  = 3,
    parameter int THRESH = 3,
    localparam int IW    = (N_CTRS > 1) ? $clog2(N_CTRS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          inc_en,
    input  logic [IW-1:0]                 inc_idx,
    input  logic                          clr_en,
    input  logic [IW-1:0]                 clr_idx,
    output logic [N_CTRS-1:0][CTR_W-1:0]  cnt_o,
    output logic [N_CTRS-1:0]             mark_o,
    output logic [CTR_W-1:0]              inc_new_o,
    output logic                          inc_sat_o
);

    localparam logic [CTR_W-1:0] MAXV = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] TV   = CTR_W'(THRESH);

    typedef struct packed {
        logic [CTR_W-1:0] cnt;
        logic             mark;
    } slot_t;

    logic [CTR_W-1:0] cur_val;

    always_comb begin
        cur_val   = cnt_o[inc_idx];
        inc_sat_o = (cur_val == MAXV);
        inc_new_o = inc_sat_o ? cur_val : cur_val + 1'b1;
    end

    // R11: flush clears and increments are kept apart by the handshake
    assert_no_collide_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_en && clr_en));

    for (genvar i = 0; i < N_CTRS; i++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr_en && (clr_idx == IW'(i))) begin
                slot_d.cnt  = '0;
                slot_d.mark = 1'b0;
            end else if (inc_en && (inc_idx == IW'(i))) begin
                slot_d.cnt = inc_new_o;
                if (inc_new_o >= TV) begin
                    slot_d.mark = 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign cnt_o[i]  = slot_q.cnt;
        assign mark_o[i] = slot_q.mark;

        // R8: the mark mirrors the threshold comparison at all times
        assert_mark_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
            slot_q.mark == (slot_q.cnt >= TV));

        // R4: a flushed slot holds zero on the next cycle
        assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && (clr_idx == IW'(i))) |=> (slot_q.cnt == '0));
    end

endmodule

// File: rtl/fs_largest_track.sv
module fs_largest_track #(
    parameter int N_CTRS = 8,
    parameter int CTR_W  = 3,
    localparam int IW    = (N_CTRS > 1) ? $clog2(N_CTRS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [IW-1:0]    upd_idx,
    input  logic [CTR_W-1:0] upd_val,
    input  logic             clr_en,
    input  logic [IW-1:0]    clr_idx,
    output logic             lg_vld_o,
    output logic [IW-1:0]    lg_idx_o,
    output logic [CTR_W-1:0] lg_val_o
);

    typedef struct packed {
        logic             vld;
        logic [IW-1:0]    idx;
        logic [CTR_W-1:0] val;
    } track_t;

    track_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (clr_en && trk_q.vld && (clr_idx == trk_q.idx)) begin
            trk_d.vld = 1'b0;
            trk_d.val = '0;
        end else if (upd_en && (!trk_q.vld || (upd_val > trk_q.val) ||
                                (upd_idx == trk_q.idx))) begin
            trk_d.vld = 1'b1;
            trk_d.idx = upd_idx;
            trk_d.val = upd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign lg_vld_o = trk_q.vld;
    assign lg_idx_o = trk_q.idx;
    assign lg_val_o = trk_q.val;

    // R9: with no flush and a valid entry, the held value never falls
    assert_track_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.vld && !clr_en) |=> (trk_q.vld && (trk_q.val >= $past(trk_q.val))));

endmodule

// File: rtl/fs_victim_pick.sv
module fs_victim_pick
    import fs_pkg::*;
#(
    parameter int N_CTRS = 8,
    parameter int CTR_W  = 3,
    parameter int THRESH = 3,
    localparam int IW    = (N_CTRS > 1) ? $clog2(N_CTRS) : 1
) (
    input  logic              lg_vld,
    input  logic [IW-1:0]     lg_idx,
    input  logic [CTR_W-1:0]  lg_val,
    input  logic [N_CTRS-1:0] mark,
    output logic [IW-1:0]     victim_o,
    output pick_e             rule_o
);

    localparam logic [CTR_W-1:0] TV = CTR_W'(THRESH);

    logic          any_mark;
    logic [IW-1:0] low_mark;

    // lowest-indexed marked counter
    always_comb begin
        any_mark = 1'b0;
        low_mark = '0;
        for (int i = N_CTRS - 1; i >= 0; i--) begin
            if (mark[i]) begin
                any_mark = 1'b1;
                low_mark = IW'(i);
            end
        end
    end

    always_comb begin
        if (lg_vld && (lg_val >= TV)) begin
            victim_o = lg_idx;
            rule_o   = PICK_TRACKED;
        end else if (any_mark) begin
            victim_o = low_mark;
            rule_o   = PICK_MARKED;
        end else begin
            victim_o = lg_idx;
            rule_o   = PICK_FALLBACK;
        end
    end

endmodule

// File: rtl/fs_flush_sched.sv
module fs_flush_sched
    import fs_pkg::*;
#(
    parameter int N_CTRS        = 8,
    parameter int CTR_W         = 3,
    parameter int THRESH        = 3,
    parameter int UPD_PER_FLUSH = 8,
    localparam int IW           = (N_CTRS > 1) ? $clog2(N_CTRS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    output logic             upd_ready,
    input  logic [IW-1:0]    upd_idx,
    output logic             flush_valid,
    output logic [IW-1:0]    flush_idx,
    output logic [CTR_W-1:0] flush_value,
    output logic             overflow
);

    localparam int               BW   = $clog2(UPD_PER_FLUSH + 1);
    localparam logic [BW-1:0]    LAST = BW'(UPD_PER_FLUSH - 1);
    localparam logic [CTR_W-1:0] TV   = CTR_W'(THRESH);

    typedef struct packed {
        logic [BW-1:0]    ucnt;
        logic             pend;
        logic             fvld;
        logic [IW-1:0]    fidx;
        logic [CTR_W-1:0] fval;
        logic             ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                         accept;
    logic [N_CTRS-1:0][CTR_W-1:0] cnt;
    logic [N_CTRS-1:0]            mark;
    logic [CTR_W-1:0]             inc_new;
    logic                         inc_sat;
    logic                         lg_vld;
    logic [IW-1:0]                lg_idx;
    logic [CTR_W-1:0]             lg_val;
    logic [IW-1:0]                victim;
    pick_e                        rule;

    assign upd_ready = !ctl_q.pend;
    assign accept    = upd_valid && upd_ready;

    fs_ctr_bank #(
        .N_CTRS (N_CTRS),
        .CTR_W  (CTR_W),
        .THRESH (THRESH)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_en    (accept),
        .inc_idx   (upd_idx),
        .clr_en    (ctl_q.pend),
        .clr_idx   (victim),
        .cnt_o     (cnt),
        .mark_o    (mark),
        .inc_new_o (inc_new),
        .inc_sat_o (inc_sat)
    );

    fs_largest_track #(
        .N_CTRS (N_CTRS),
        .CTR_W  (CTR_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (accept),
        .upd_idx  (upd_idx),
        .upd_val  (inc_new),
        .clr_en   (ctl_q.pend),
        .clr_idx  (victim),
        .lg_vld_o (lg_vld),
        .lg_idx_o (lg_idx),
        .lg_val_o (lg_val)
    );

    fs_victim_pick #(
        .N_CTRS (N_CTRS),
        .CTR_W  (CTR_W),
        .THRESH (THRESH)
    ) u_pick (
        .lg_vld   (lg_vld),
        .lg_idx   (lg_idx),
        .lg_val   (lg_val),
        .mark     (mark),
        .victim_o (victim),
        .rule_o   (rule)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.fvld = 1'b0;
        if (accept) begin
            if (ctl_q.ucnt == LAST) begin
                ctl_d.ucnt = '0;
                ctl_d.pend = 1'b1;
            end else begin
                ctl_d.ucnt = ctl_q.ucnt + 1'b1;
            end
            if (inc_sat) begin
                ctl_d.ovf = 1'b1;
            end
        end
        if (ctl_q.pend) begin
            ctl_d.pend = 1'b0;
            ctl_d.fvld = 1'b1;
            ctl_d.fidx = victim;
            ctl_d.fval = cnt[victim];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign flush_valid = ctl_q.fvld;
    assign flush_idx   = ctl_q.fidx;
    assign flush_value = ctl_q.fval;
    assign overflow    = ctl_q.ovf;

    // R3: the flush port pulses for a single cycle
    assert_flush_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> !flush_valid);

    // R3: the flush slot is followed by the flush report
    assert_slot_then_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_ready |=> (flush_valid && upd_ready));

    // R4: the reported counter reads zero while it is reported
    assert_flushed_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (cnt[flush_idx] == '0));

    // R5: a tracked counter at threshold wins the slot
    assert_tracked_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.pend && lg_vld && (lg_val >= TV)) |=> (flush_idx == $past(lg_idx)));

    // R6: a marked counter is reported only while it held the threshold
    assert_marked_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.pend && (rule == PICK_MARKED)) |-> (cnt[victim] >= TV));

    // R9: the tracker always mirrors the counter it names
    assert_track_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lg_vld |-> (lg_val == cnt[lg_idx]));

    // R10: overflow is sticky
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

// File: tb/tb_fs_flush_sched.sv
module tb_fs_flush_sched;

    localparam int CLK_P = 10;
    localparam int N     = 8;
    localparam int CW    = 3;
    localparam int T     = 3;
    localparam int B     = 8;
    localparam int IW    = $clog2(N);
    localparam int MAXV  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_valid = 1'b0;
    logic [IW-1:0] upd_idx = '0;
    logic          upd_ready;
    logic          flush_valid;
    logic [IW-1:0] flush_idx;
    logic [CW-1:0] flush_value;
    logic          overflow;

    fs_flush_sched #(
        .N_CTRS (N), .CTR_W (CW), .THRESH (T), .UPD_PER_FLUSH (B)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .upd_valid (upd_valid), .upd_ready (upd_ready), .upd_idx (upd_idx),
        .flush_valid (flush_valid), .flush_idx (flush_idx),
        .flush_value (flush_value), .overflow (overflow)
    );

    always #(CLK_P / 2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    // reference state
    int    mc[N];
    bit    mk[N];
    bit    lv;
    int    li, lval;
    int    ucnt;
    bit    ovf_m;
    bit    ep;
    int    ep_age;
    int    e_idx, e_val;
    string e_tag;
    int    rule_hits[3];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            mc[i] = 0;
            mk[i] = 1'b0;
        end
        lv = 1'b0; li = 0; lval = 0; ucnt = 0; ovf_m = 1'b0; ep = 1'b0; ep_age = 0;
    endtask

    // applies one accepted update (R2, R8, R9, R10) and schedules the flush (R3..R7)
    task automatic model_apply(input int idx);
        int nv;
        int v;
        nv = (mc[idx] == MAXV) ? MAXV : mc[idx] + 1;
        if (mc[idx] == MAXV) ovf_m = 1'b1;
        mc[idx] = nv;
        if (nv >= T) mk[idx] = 1'b1;
        if (!lv || nv > lval || idx == li) begin
            lv = 1'b1; li = idx; lval = nv;
        end
        ucnt++;
        if (ucnt == B) begin
            ucnt = 0;
            v = -1;
            if (lv && lval >= T) begin
                v = li; e_tag = "R5"; rule_hits[0]++;
            end else begin
                for (int i = N - 1; i >= 0; i--) if (mk[i]) v = i;
                if (v >= 0) begin
                    e_tag = "R6"; rule_hits[1]++;
                end else begin
                    v = li; e_tag = "R7"; rule_hits[2]++;
                end
            end
            e_idx = v;
            e_val = mc[v];
            mc[v] = 0;
            mk[v] = 1'b0;
            if (lv && li == v) lv = 1'b0;
            ep = 1'b1;
            ep_age = 0;
        end
    endtask

    // R11: the request is held while upd_ready is 0 and counted only once taken
    task automatic push(input int idx);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_idx   = IW'(idx);
        forever begin
            if (upd_ready) begin
                @(posedge clk);
                model_apply(idx);
                break;
            end
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        upd_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        mon_on = 1'b0;
        @(negedge clk);
        upd_valid = 1'b0;
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(upd_ready == 1'b1, "R1 ready after reset", int'(upd_ready), 1);
        chk(flush_valid == 1'b0, "R1 flush idle after reset", int'(flush_valid), 0);
        chk(overflow == 1'b0, "R1 overflow clear after reset", int'(overflow), 0);
        mon_on = 1'b1;
    endtask

    // flush port and handshake monitor
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (flush_valid) begin
                chk(ep, "R3 unexpected flush", int'(flush_valid), int'(ep));
                chk(int'(flush_idx) == e_idx, {e_tag, " flush index"}, int'(flush_idx), e_idx);
                chk(int'(flush_value) == e_val, "R4 flush value", int'(flush_value), e_val);
                chk(upd_ready == 1'b1, "R3 ready restored at flush", int'(upd_ready), 1);
                ep = 1'b0;
            end else if (ep) begin
                ep_age++;
                chk(upd_ready == 1'b0, "R3 ready low in flush slot", int'(upd_ready), 0);
                chk(ep_age <= 1, "R3 flush late", ep_age, 1);
            end
            chk(overflow == ovf_m, "R10 overflow flag", int'(overflow), int'(ovf_m));
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit [15:0] lfsr;
        for (int i = 0; i < 3; i++) rule_hits[i] = 0;
        do_reset();

        // R5: two counters pass threshold, the tracked one (idx 2, tie keeps it) goes
        for (int k = 0; k < 4; k++) push(2);
        for (int k = 0; k < 4; k++) push(5);
        // R6: tracker refilled below threshold, idx 5 still marked
        for (int k = 0; k < 2; k++) begin
            push(0); push(1); push(3); push(4);
        end
        // R7: nobody marked, tracked counter flushed anyway
        for (int k = 0; k < 2; k++) begin
            push(6); push(7); push(2); push(5);
        end
        idle(3);
        chk(rule_hits[0] >= 1 && rule_hits[1] >= 1 && rule_hits[2] >= 1,
            "R5 R6 R7 each rule seen in directed phase",
            rule_hits[0] * 100 + rule_hits[1] * 10 + rule_hits[2], 111);

        // R10: saturate idx 7 while it is never flushed before reaching the top
        chk(overflow == 1'b0, "R10 no overflow yet", int'(overflow), 0);
        for (int k = 0; k < 8; k++) push(7);
        idle(3);
        chk(overflow == 1'b1, "R10 overflow after saturating", int'(overflow), 1);

        // R2 R9: sweep of rotating and hammered patterns, back-to-back through slots
        for (int s = 0; s < N; s++) begin
            for (int k = 0; k < 3 * B; k++) push((s + k * (s + 1)) % N);
            for (int k = 0; k < B + 1; k++) push(s);
        end

        // pseudo-random stream with gaps
        lfsr = 16'hACE1;
        for (int k = 0; k < 4000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[15:13] == 3'b000) idle(int'(lfsr[1:0]));
            push(int'(lfsr[IW-1:0]) ^ int'(lfsr[8:6] & 3'b011));
        end
        idle(4);
        chk(rule_hits[0] > 0 && rule_hits[1] > 0 && rule_hits[2] > 0,
            "R5 R6 R7 rules across whole run", rule_hits[1], 1);

        // R1 R10: reset clears the sticky flag and all counters
        do_reset();
        for (int k = 0; k < B; k++) push(k % N);
        idle(4);
        chk(ep == 1'b0, "R1 flush after reset seen", int'(ep), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule